// File: doc/BRIEF.md
# Dual Parallel Port Register File

This block keeps two 8-bit parallel ports behind a small register bus. Each port has an output latch and a direction mask. A mask bit of 1 makes that pin an output. For each pin, the value driven onto the port bus is the latch bit when the pin is an output, and logic 1 when the pin is an input. A write to either register of a port recomputes that port's drive value. The same write also raises a one-cycle update strobe for that port alone, so a neighbouring block can resample the pins.

Only the low four bits of the bus address select a register. Registers 4 to 15 have no effect on the ports: they are plain storage locations that read back whatever was written to them. Both reads and writes are synchronous. Read data is registered and appears on the cycle after the read request.

Top module: `pp_regfile`

## Requirements
- R1: Only `addr_i[3:0]` selects a register. The upper address bits have no effect on any read or write.
- R2: While `rst_ni` is low, and after it is released, all latches and direction masks are 0. Both drive buses read 0xFF, `port_upd_o` is 0 and `rdata_o` is 0.
- R3: Each drive bus equals its port's output latch OR the bitwise inverse of its direction mask. Every input pin therefore drives 1.
- R4: A write to register 0 sets the port A latch, and a write to register 1 sets the port B latch. The drive bus shows the new value from the clock edge that takes the write.
- R5: A write to register 2 sets the port A direction mask, and a write to register 3 sets the port B mask. A mask bit of 1 means output.
- R6: Bit 0 of `port_upd_o` belongs to port A and bit 1 to port B. On every write to a port's latch or mask, that port's bit is high for exactly the one cycle after the write edge, even when the stored value does not change. The other port's bit stays low.
- R7: A read (`rd_en_i` high at an edge) updates `rdata_o` at that edge. A read of register 2 or 3 returns the stored direction mask. Without a read request, `rdata_o` holds its value.
- R8: A read of register 0 or 1 returns that port's current drive value, not the raw latch.
- R9: Registers 4 to 15 store written bytes and return them on read. Writes to them change neither drive bus nor `port_upd_o`.
- R10: When a read and a write address the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Register address; only the low 4 bits are decoded |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| port_a_drive_o | output | 8 | Port A pin drive value |
| port_b_drive_o | output | 8 | Port B pin drive value |
| port_upd_o | output | 2 | Per-port update strobe (bit 0 = A, bit 1 = B) |

## Verification
A read and a write can fall in the same cycle and on the same register. This case needs care for registers 0 and 1, because the read returns the drive value, and the drive value depends on the latch that the write is changing. The bench issues same-address read/write pairs on every register class, both in directed steps and with about a third probability among the random operations. It expects the read to return the value the bench model held before that write's update. In the following cycle it also checks that the drive bus and the strobe already show the write.

// File: rtl/pp_regfile_pkg.sv
package pp_regfile_pkg;
  parameter int DATA_W    = 8;
  parameter int REG_AW    = 4;
  parameter int NUM_PORTS = 2;

  localparam int NUM_REGS = 1 << REG_AW;
  localparam int DIR_BASE = NUM_PORTS;
  localparam int SCR_BASE = 2 * NUM_PORTS;
  localparam int SCR_CNT  = NUM_REGS - SCR_BASE;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef struct packed {
    logic     we;
    reg_idx_t idx;
    byte_t    wdata;
  } wr_req_t;
endpackage

// File: rtl/pp_port.sv
module pp_port
  import pp_regfile_pkg::*;
#(
  parameter int PIDX = 0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_req_t req_i,
  output byte_t   drive_o,
  output byte_t   dir_o,
  output logic    upd_o
);
  localparam reg_idx_t LAT_IDX = reg_idx_t'(PIDX);
  localparam reg_idx_t DIR_IDX = reg_idx_t'(DIR_BASE + PIDX);

  byte_t lat_q, dir_q;
  logic  lat_we, dir_we;

  assign lat_we = req_i.we && (req_i.idx == LAT_IDX);
  assign dir_we = req_i.we && (req_i.idx == DIR_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      dir_q <= '0;
      upd_o <= 1'b0;
    end else begin
      if (lat_we) lat_q <= req_i.wdata;
      if (dir_we) dir_q <= req_i.wdata;
      upd_o <= lat_we | dir_we;
    end
  end

  // input pins float high
  assign drive_o = lat_q | ~dir_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/pp_scratch.sv
module pp_scratch
  import pp_regfile_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wr_req_t  req_i,
  input  reg_idx_t rd_idx_i,
  output byte_t    rdata_o
);
  byte_t mem_q [SCR_CNT];

  for (genvar g = 0; g < SCR_CNT; g++) begin : g_ent
    localparam reg_idx_t ENT_IDX = reg_idx_t'(SCR_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (req_i.we && req_i.idx == ENT_IDX) mem_q[g] <= req_i.wdata;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < SCR_CNT; i++)
      if (rd_idx_i == reg_idx_t'(SCR_BASE + i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/pp_rd_mux.sv
module pp_rd_mux
  import pp_regfile_pkg::*;
(
  input  reg_idx_t                         idx_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] drive_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] dir_i,
  input  byte_t                            scr_i,
  output byte_t                            data_o
);
  always_comb begin
    data_o = scr_i;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx_i == reg_idx_t'(p))            data_o = drive_i[p];
      if (idx_i == reg_idx_t'(DIR_BASE + p)) data_o = dir_i[p];
    end
  end
endmodule

// File: rtl/pp_regfile.sv
module pp_regfile
  import pp_regfile_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        port_a_drive_o,
  output logic [7:0]        port_b_drive_o,
  output logic [1:0]        port_upd_o
);
  wr_req_t  req;
  reg_idx_t idx;
  logic [NUM_PORTS-1:0][DATA_W-1:0] drive, dir;
  logic [NUM_PORTS-1:0]             upd;
  byte_t scr_rd, rd_mux, rdata_q;

  assign idx       = addr_i[REG_AW-1:0];
  assign req.we    = wr_en_i;
  assign req.idx   = idx;
  assign req.wdata = wdata_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    byte_t drv_w, dir_w;
    pp_port #(.PIDX(p)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req),
      .drive_o (drv_w),
      .dir_o   (dir_w),
      .upd_o   (upd[p])
    );
    assign drive[p] = drv_w;
    assign dir[p]   = dir_w;
  end

  pp_scratch u_scr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .rd_idx_i (idx),
    .rdata_o  (scr_rd)
  );

  pp_rd_mux u_mux (
    .idx_i   (idx),
    .drive_i (drive),
    .dir_i   (dir),
    .scr_i   (scr_rd),
    .data_o  (rd_mux)
  );

  // read samples pre-write state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o        = rdata_q;
  assign port_a_drive_o = drive[0];
  assign port_b_drive_o = drive[1];
  assign port_upd_o     = upd;
endmodule

// File: rtl/pp_regfile_chk.sv
module pp_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        port_a_drive_o,
  input logic [7:0]        port_b_drive_o,
  input logic [1:0]        port_upd_o
);
  // R4
  lat_a_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[3:0] == 4'd0) |=> ((port_a_drive_o & $past(wdata_i)) == $past(wdata_i)));

  // R5
  dir_b_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[3:0] == 4'd3) |=> ((port_b_drive_o | $past(wdata_i)) == 8'hFF));

  // R6
  upd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_upd_o));

  // R6
  upd_a_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_upd_o[0] |-> $past(wr_en_i && (addr_i[3:0] == 4'd0 || addr_i[3:0] == 4'd2)));

  // R6
  upd_b_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i[3:0] == 4'd1 || addr_i[3:0] == 4'd3)) |=> port_upd_o[1]);

  // R9
  scr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[3:0] >= 4'd4) |=>
      (port_upd_o == 2'b00 && $stable(port_a_drive_o) && $stable(port_b_drive_o)));

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind pp_regfile pp_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/pp_regfile_tb_top.sv
`timescale 1ns/1ps
module pp_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, drv_a, drv_b;
  logic [1:0] upd;

  int checks = 0, fails = 0;
  logic [7:0] lat [2];
  logic [7:0] dir [2];
  logic [7:0] scr [16];
  logic [7:0] exp_rd = '0;

  always #4 clk = ~clk;

  pp_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .port_a_drive_o(drv_a), .port_b_drive_o(drv_b), .port_upd_o(upd)
  );

  function automatic logic [7:0] drive_of(int p);
    return lat[p] | ~dir[p];
  endfunction

  function automatic logic [7:0] model_rd(logic [3:0] i);
    if (i < 2)      return drive_of(i);
    else if (i < 4) return dir[i-2];
    else            return scr[i];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic op(bit we, bit re, logic [7:0] a, logic [7:0] d);
    logic [3:0] i;
    logic [1:0] eu;
    string rtag;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk);
    i = a[3:0];
    eu = 2'b00;
    if (re) exp_rd = model_rd(i); // R10: pre-write value
    if (we) begin
      if (i < 2)      begin lat[i] = d;   eu[i] = 1'b1;   end
      else if (i < 4) begin dir[i-2] = d; eu[i-2] = 1'b1; end
      else            scr[i] = d;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rtag = (i < 2) ? "R8/R10" : (i < 4) ? "R7/R10" : "R9/R10";
    chk(re ? rtag : "R7 hold", rdata, exp_rd);
    chk("R3/R4/R5 port A", drv_a, drive_of(0));
    chk("R3/R4/R5 port B", drv_b, drive_of(1));
    chk("R6 strobe", {6'd0, upd}, {6'd0, eu});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 2; k++) begin lat[k] = '0; dir[k] = '0; end
    for (int k = 0; k < 16; k++) scr[k] = '0;

    repeat (3) @(negedge clk);
    // R2: state during reset
    chk("R2 rst drv A", drv_a, 8'hFF);
    chk("R2 rst rdata", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 drv A", drv_a, 8'hFF);
    chk("R2 drv B", drv_b, 8'hFF);
    chk("R2 upd", {6'd0, upd}, 8'h00);
    chk("R2 rdata", rdata, 8'h00);

    // R4/R3: latch alone, all inputs -> FF
    op(1, 0, 8'h00, 8'hA5);
    // R5: half outputs
    op(1, 0, 8'h02, 8'h0F);
    chk("R3 A mixed", drv_a, 8'hF5);
    // R1: upper bits ignored, read dir A via 0x32
    op(0, 1, 8'h32, 8'h00);
    chk("R1 alias read", rdata, 8'h0F);
    // R1: write via aliased address to B dir
    op(1, 0, 8'hE3, 8'hFF);
    op(1, 0, 8'h71, 8'h3C);
    chk("R1 R4 B full out", drv_b, 8'h3C);
    // R8: read latch reg returns drive
    op(0, 1, 8'h00, 8'h00);
    chk("R8 drive read", rdata, 8'hF5);
    // R6: rewrite same value still pulses
    op(1, 0, 8'h01, 8'h3C);
    // R10: simultaneous rd/wr same reg
    op(1, 1, 8'h02, 8'hFF);
    chk("R10 old dir", rdata, 8'h0F);
    op(1, 1, 8'h00, 8'h00);
    chk("R10 old drive", rdata, 8'hA5);
    // R9: scratch ends
    op(1, 0, 8'h04, 8'h11);
    op(1, 0, 8'hFF, 8'hEE);
    op(0, 1, 8'h0F, 8'h00);
    chk("R9 scr15", rdata, 8'hEE);
    op(0, 1, 8'h84, 8'h00);
    chk("R9 scr4", rdata, 8'h11);
    // R7: idle cycles hold rdata
    op(0, 0, 8'h02, 8'h00);

    for (int n = 0; n < 600; n++) begin
      bit we, re;
      logic [7:0] a, d;
      we = ($urandom % 3) != 0;
      re = ($urandom % 2) != 0;
      a  = 8'($urandom);
      d  = 8'($urandom);
      if (($urandom % 3) == 0) a[3:0] = 4'($urandom % 4);
      op(we, re, a, d);
    end
    summary();
  end
endmodule